// File: doc/BRIEF.md
# Passive-Matrix STN Row Timing Controller

This block feeds a passive-matrix STN panel of 320 pixels by three colour sub-pixels by 240 rows, scanned as one panel at a 1/240 duty ratio. It takes display data from a ready/valid stream, one word per transfer. Each word holds eight adjacent sub-pixel dots that are already packed, with the leftmost dot in the first word of a row. The block sends each word to the panel's column shift registers on one shift-clock period. Each row therefore takes 120 shift clocks.

When a row is complete, the block commits it with a latch pulse and then starts the next row at once. The panel shows row N while row N+1 is being shifted in. A start-of-frame marker rides on the latch pulse that ends a frame. A polarity line inverts once per frame so that the liquid crystal never carries a net DC bias. A programmable idle time follows each latch pulse. If the stream runs dry in the middle of a row, the shift clock stops and a sticky error flag is raised. The row sequence and the polarity are not affected.

The row length, bus width, row count and latch width are parameters. The defaults match the 960-dot, 240-row panel.

Top module: `stn_panel_tcon`

## Requirements
- R1: While `rst_n` is low at a clock edge, and right after such an edge, `lcd_xck`, `lcd_lp`, `lcd_yd`, `lcd_m` and `underrun` are 0 and `lcd_d` is all zeros.
- R2: Every row sends exactly DOTS_PER_ROW/BUS_W words (120 by default). Each accepted stream word appears on `lcd_d` on the clock edge where `lcd_xck` rises. Words appear in arrival order, and the word order carries on across rows and frames.
- R3: `lcd_xck` is high for exactly one system clock per word, and `lcd_d` does not change on the edge where `lcd_xck` falls. With data always available, a row shifts at half the system clock rate.
- R4: `lcd_lp` rises on the first clock edge after the `lcd_xck` fall of a row's last word. It stays high for 2×LP_XCK system clocks (4 by default).
- R5: While `lcd_lp` is high, `lcd_xck` is low and `px_ready` is low.
- R6: Counting latch pulses from reset, pulse number k (starting at k=0) with k mod ROWS = ROWS−1 has `lcd_yd` high for exactly its duration. `lcd_yd` is low at all other times.
- R7: `lcd_m` is 0 after reset. It inverts on the clock edge where a pulse that carried `lcd_yd` falls, and it holds its value at every other edge.
- R8: If `px_valid` stays high, the next `lcd_xck` rise comes exactly `idle_cycles`+1 system clocks after the `lcd_lp` fall. `idle_cycles` is sampled during the latch pulse and the idle time that follows it.
- R9: If `px_valid` is low after the first word of a row and before its last, `lcd_xck` stays low and `underrun` becomes 1. `underrun` stays 1 until reset. When data returns, the word order, the latch/marker row count and `lcd_m` carry on as if no stall had happened.
- R10: If `px_valid` is low before the first word of a row, the block just waits. `lcd_xck` does not rise and `underrun` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_cycles | input | IDLE_W | System clocks of idle time after each latch pulse |
| px_data | input | BUS_W | Packed sub-pixel word; the leftmost dot comes first within a row |
| px_valid | input | 1 | Stream word available |
| px_ready | output | 1 | Block takes the word at this edge when valid |
| lcd_d | output | BUS_W | Panel data bus |
| lcd_xck | output | 1 | Column shift clock; the panel samples on its falling edge |
| lcd_lp | output | 1 | Row latch pulse; the row commits on its falling edge |
| lcd_yd | output | 1 | Start-of-frame marker for the scan driver |
| lcd_m | output | 1 | Frame polarity for the AC drive |
| underrun | output | 1 | Sticky flag for a mid-row stream stall |

## Verification
The assertions check several properties on every clock. They check that the shift clock is a one-cycle pulse with data held across its fall, and that the shift clock and stream handshake stay idle while the latch is high. They check that a completed row is always followed by the latch, that the frame marker appears only inside a latch pulse, that polarity changes only just after a marked pulse, and that the underrun flag never clears by itself. The bench scenarios cover what needs counting over whole rows and frames: the word count per row, the word order across stalls and resets, the latch width, the idle gap for several programmed values, the frame period of the marker and the polarity, and the difference between a stall at a row start and a stall in the middle of a row.

// File: rtl/stn_tcon_pkg.sv
// Shared types for the STN row timing controller.
// Assumes: nothing beyond IEEE 1800-2017.
package stn_tcon_pkg;

    // Phases of one row period.
    typedef enum logic [1:0] {
        LS_SHIFT = 2'd0,
        LS_LATCH = 2'd1,
        LS_IDLE  = 2'd2
    } line_state_e;

endpackage

// File: rtl/stn_row_shift.sv
// Moves one row of packed sub-pixel words from the stream onto the panel
// bus. Each accepted word drives the shift clock high for one cycle and
// low for at least one, so the data is stable at the falling edge. It
// raises row_done once every word of the row has gone out.
// Assumes: en is held high by the sequencer for the whole shift phase.
module stn_row_shift #(
    parameter int DW    = 8,
    parameter int WORDS = 120
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    output logic          in_ready,
    output logic [DW-1:0] d_out,
    output logic          xck,
    output logic          row_done,
    output logic          underrun
);
    localparam int             CW   = $clog2(WORDS + 1);
    localparam logic [CW-1:0]  LAST = CW'(WORDS);

    logic [CW-1:0] word_cnt;

    // Take a word only in the low half of the shift clock while words remain.
    assign in_ready = en && !xck && (word_cnt != LAST);
    // The row is finished once the final word's clock has come back low.
    assign row_done = en && !xck && (word_cnt == LAST);

    // Word transfer, shift clock pulse, row wrap and the stall flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xck      <= 1'b0;
            d_out    <= '0;
            word_cnt <= '0;
            underrun <= 1'b0;
        end else if (xck) begin
            xck <= 1'b0;
        end else if (in_ready && in_valid) begin
            d_out    <= in_data;
            xck      <= 1'b1;
            word_cnt <= word_cnt + 1'b1;
        end else if (row_done) begin
            word_cnt <= '0;
        end else if (in_ready && (word_cnt != '0)) begin
            underrun <= 1'b1;
        end
    end

    // R3: the shift clock is a single-cycle pulse.
    assert_xck_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xck |=> !xck);
    // R3: data holds across the sampling edge.
    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xck) |-> $stable(d_out));
    // R9: the stall flag is sticky.
    assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

endmodule

// File: rtl/stn_line_seq.sv
// Sequences one row period: shift phase, latch pulse of LP_SYS system
// clocks, then a programmable idle time before the next shift phase.
// Assumes: LP_SYS >= 2; idle_cycles is held steady during latch and idle.
module stn_line_seq
    import stn_tcon_pkg::*;
#(
    parameter int LP_SYS = 4,
    parameter int IW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          row_done,
    input  logic [IW-1:0] idle_cycles,
    output logic          shift_en,
    output logic          lp,
    output logic          lp_end
);
    localparam int            LW      = $clog2(LP_SYS);
    localparam logic [LW-1:0] LP_LAST = LW'(LP_SYS - 1);

    line_state_e   state;
    logic [LW-1:0] lp_cnt;
    logic [IW-1:0] idle_cnt;

    assign shift_en = (state == LS_SHIFT);
    assign lp       = (state == LS_LATCH);
    // Last cycle of the latch pulse; the next edge drops it.
    assign lp_end   = (state == LS_LATCH) && (lp_cnt == LP_LAST);

    // Row-period state machine with the latch and idle counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= LS_SHIFT;
            lp_cnt   <= '0;
            idle_cnt <= '0;
        end else begin
            case (state)
                LS_SHIFT: begin
                    if (row_done) begin
                        state  <= LS_LATCH;
                        lp_cnt <= '0;
                    end
                end
                LS_LATCH: begin
                    if (lp_end) begin
                        state    <= (idle_cycles == '0) ? LS_SHIFT : LS_IDLE;
                        idle_cnt <= IW'(1);
                    end else begin
                        lp_cnt <= lp_cnt + 1'b1;
                    end
                end
                LS_IDLE: begin
                    if (idle_cnt >= idle_cycles) state <= LS_SHIFT;
                    else idle_cnt <= idle_cnt + 1'b1;
                end
                default: state <= LS_SHIFT;
            endcase
        end
    end

    // R4: a finished row is latched on the very next edge.
    assert_latch_follows_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |=> lp);

endmodule

// File: rtl/stn_frame_track.sv
// Counts latched rows inside a frame, marks the pulse that closes the
// last row with the frame marker, and inverts the drive polarity as
// that pulse ends.
// Assumes: ROWS >= 2; lp_end falls inside an lp pulse.
module stn_frame_track #(
    parameter int ROWS = 240
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lp,
    input  logic lp_end,
    output logic yd,
    output logic m
);
    localparam int            RW       = $clog2(ROWS);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    logic [RW-1:0] row_idx;

    assign yd = lp && (row_idx == LAST_ROW);

    // Advance the row index per latch; wrap and flip polarity per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_idx <= '0;
            m       <= 1'b0;
        end else if (lp_end) begin
            if (row_idx == LAST_ROW) begin
                row_idx <= '0;
                m       <= ~m;
            end else begin
                row_idx <= row_idx + 1'b1;
            end
        end
    end

    // R6: the marker only appears inside a latch pulse.
    assert_yd_in_lp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        yd |-> lp);
    // R7: polarity moves only right after a marked pulse.
    assert_m_on_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(m) |-> $past(yd));

endmodule

// File: rtl/stn_panel_tcon.sv
// Top of the STN row timing controller. It joins the word shifter, the
// row-period sequencer and the frame tracker.
// Assumes: DOTS_PER_ROW is a multiple of BUS_W; stream words are packed
// with the leftmost dot of a row in the first word.
module stn_panel_tcon #(
    parameter int DOTS_PER_ROW = 960,
    parameter int BUS_W        = 8,
    parameter int ROWS         = 240,
    parameter int LP_XCK       = 2,
    parameter int IDLE_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDLE_W-1:0] idle_cycles,
    input  logic [BUS_W-1:0]  px_data,
    input  logic              px_valid,
    output logic              px_ready,
    output logic [BUS_W-1:0]  lcd_d,
    output logic              lcd_xck,
    output logic              lcd_lp,
    output logic              lcd_yd,
    output logic              lcd_m,
    output logic              underrun
);
    localparam int WORDS  = DOTS_PER_ROW / BUS_W;
    localparam int LP_SYS = 2 * LP_XCK;

    logic shift_en;
    logic row_done;
    logic lp_end;

    stn_row_shift #(.DW(BUS_W), .WORDS(WORDS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (shift_en),
        .in_data  (px_data),
        .in_valid (px_valid),
        .in_ready (px_ready),
        .d_out    (lcd_d),
        .xck      (lcd_xck),
        .row_done (row_done),
        .underrun (underrun)
    );

    stn_line_seq #(.LP_SYS(LP_SYS), .IW(IDLE_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_done    (row_done),
        .idle_cycles (idle_cycles),
        .shift_en    (shift_en),
        .lp          (lcd_lp),
        .lp_end      (lp_end)
    );

    stn_frame_track #(.ROWS(ROWS)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .lp     (lcd_lp),
        .lp_end (lp_end),
        .yd     (lcd_yd),
        .m      (lcd_m)
    );

    // R5: no shifting during the latch pulse.
    assert_xck_quiet_in_lp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_lp |-> !lcd_xck);
    // R5: the stream is held off during the latch pulse.
    assert_no_take_in_lp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_lp |-> !px_ready);

endmodule

// File: tb/sim_stn_panel_tcon.sv
// Bench for stn_panel_tcon with a short panel. A monitor follows the panel
// pins every cycle. A vector table sets idle time and data seed per frame;
// directed tests follow.
module sim_stn_panel_tcon;
    localparam int T_DOTS  = 64;
    localparam int T_BUS   = 8;
    localparam int T_ROWS  = 4;
    localparam int T_WORDS = T_DOTS / T_BUS;
    localparam int T_LPSYS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] idle_cycles = 8'd0;
    logic [7:0] px_data;
    logic       px_valid = 1'b0;
    logic       px_ready;
    logic [7:0] lcd_d;
    logic       lcd_xck, lcd_lp, lcd_yd, lcd_m, underrun;

    int checks = 0;
    int errors = 0;
    int seed = 0;
    int exp_gap = 1;
    int sent_cnt = 0;
    bit finished = 1'b0;

    // monitor state
    int  rx_cnt = 0, words_in_row = 0, lp_falls = 0, lp_width = 0;
    int  gap_cnt = 0, rise_cnt = 0, since_fall = 0;
    bit  gap_armed = 1'b0, gap_ok = 1'b0, prev_xck = 1'b0, prev_lp = 1'b0;

    always #5 clk = ~clk;

    stn_panel_tcon #(.DOTS_PER_ROW(T_DOTS), .BUS_W(T_BUS), .ROWS(T_ROWS),
                     .LP_XCK(2), .IDLE_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .idle_cycles(idle_cycles),
        .px_data(px_data), .px_valid(px_valid), .px_ready(px_ready),
        .lcd_d(lcd_d), .lcd_xck(lcd_xck), .lcd_lp(lcd_lp), .lcd_yd(lcd_yd),
        .lcd_m(lcd_m), .underrun(underrun)
    );

    function automatic logic [7:0] pat(input int i, input int s);
        int t;
        t = i * 37 + s * 11 + 3;
        return t[7:0];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    assign px_data = pat(sent_cnt, seed);

    // Stream source: advance on every accepted word.
    always @(posedge clk) begin
        if (!rst_n) sent_cnt <= 0;
        else if (px_valid && px_ready) sent_cnt <= sent_cnt + 1;
    end

    // Pin monitor, sampled at the falling system clock edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            rx_cnt = 0; words_in_row = 0; lp_falls = 0; lp_width = 0;
            gap_cnt = 0; rise_cnt = 0; since_fall = 0;
            gap_armed = 1'b0; gap_ok = 1'b0; prev_xck = 1'b0; prev_lp = 1'b0;
        end else begin
            if (prev_xck) chk(!lcd_xck, "R3 xck high more than one clock", int'(lcd_xck), 0);
            if (lcd_xck && !prev_xck) begin
                chk(lcd_d == pat(rx_cnt, seed), "R2 word order", int'(lcd_d), int'(pat(rx_cnt, seed)));
                if (gap_armed && gap_ok)
                    chk(gap_cnt == exp_gap, "R8 idle gap", gap_cnt, exp_gap);
                gap_armed = 1'b0;
                rx_cnt++; words_in_row++; rise_cnt++;
            end
            if (lcd_lp) begin
                chk(!lcd_xck, "R5 xck during lp", int'(lcd_xck), 0);
                chk(!px_ready, "R5 ready during lp", int'(px_ready), 0);
            end
            if (lcd_lp && !prev_lp) begin
                chk(words_in_row == T_WORDS, "R2 words per row", words_in_row, T_WORDS);
                chk(since_fall == 0, "R4 lp start after last xck fall", since_fall, 0);
                words_in_row = 0;
                lp_width = 0;
            end
            if (lcd_lp) lp_width++;
            if (!lcd_lp && prev_lp) begin
                chk(lp_width == T_LPSYS, "R4 lp width", lp_width, T_LPSYS);
                lp_falls++;
                gap_armed = 1'b1; gap_cnt = 0; gap_ok = 1'b1;
            end
            if (gap_armed) begin
                gap_cnt++;
                if (!px_valid) gap_ok = 1'b0;
            end
            chk(lcd_yd == (lcd_lp && ((lp_falls % T_ROWS) == T_ROWS - 1)), "R6 frame marker",
                int'(lcd_yd), int'(lcd_lp && ((lp_falls % T_ROWS) == T_ROWS - 1)));
            chk(lcd_m == ((lp_falls / T_ROWS) % 2 == 1), "R7 polarity",
                int'(lcd_m), (lp_falls / T_ROWS) % 2);
            if (!lcd_xck && prev_xck) since_fall = 0;
            else since_fall++;
            prev_xck = lcd_xck;
            prev_lp  = lcd_lp;
        end
    end

    // Vector table: {idle_cycles, data seed, expected gap to next xck rise}.
    localparam int NV = 4;
    localparam logic [23:0] VEC [NV] = '{
        {8'd0, 8'd1, 8'd1},
        {8'd3, 8'd2, 8'd4},
        {8'd1, 8'd5, 8'd2},
        {8'd9, 8'd7, 8'd10}
    };

    task automatic wait_in_lp();
        do @(negedge clk); while (!lcd_lp);
    endtask

    task automatic wait_falls(input int n);
        int target;
        target = lp_falls + n;
        while (lp_falls < target) @(negedge clk);
    endtask

    task automatic check_reset_pins();
        chk(!lcd_xck, "R1 xck in reset", int'(lcd_xck), 0);
        chk(!lcd_lp, "R1 lp in reset", int'(lcd_lp), 0);
        chk(!lcd_yd, "R1 yd in reset", int'(lcd_yd), 0);
        chk(!lcd_m, "R1 m in reset", int'(lcd_m), 0);
        chk(!underrun, "R1 underrun in reset", int'(underrun), 0);
        chk(lcd_d == 8'd0, "R1 data in reset", int'(lcd_d), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        int rc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_pins();

        // R10: no data at the start of the first row is a plain wait.
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(rise_cnt == 0, "R10 no xck without data", rise_cnt, 0);
        chk(!underrun, "R10 no underrun at row start", int'(underrun), 0);
        px_valid = 1'b1;

        // Table walk: one frame per vector, set while the latch is high.
        for (int v = 0; v < NV; v++) begin
            wait_in_lp();
            idle_cycles = VEC[v][23:16];
            seed        = int'(VEC[v][15:8]);
            exp_gap     = int'(VEC[v][7:0]);
            wait_falls(T_ROWS);
        end

        // R10: hold off data across a row start after a latch.
        wait_in_lp();
        px_valid = 1'b0;
        repeat (30) @(negedge clk);
        chk(!underrun, "R10 stall between rows", int'(underrun), 0);
        px_valid = 1'b1;
        wait_falls(2);

        // R9: stall in the middle of a row.
        rc = rise_cnt + 3;
        while (rise_cnt < rc) @(negedge clk);
        px_valid = 1'b0;
        rc = rise_cnt;
        repeat (12) @(negedge clk);
        chk(rise_cnt == rc, "R9 xck halted in stall", rise_cnt, rc);
        chk(!lcd_xck, "R9 xck low in stall", int'(lcd_xck), 0);
        chk(underrun, "R9 underrun raised", int'(underrun), 1);
        px_valid = 1'b1;
        wait_falls(2 * T_ROWS);
        chk(underrun, "R9 underrun sticky", int'(underrun), 1);

        // R1: reset in the middle of a row clears everything.
        rc = rise_cnt + 2;
        while (rise_cnt < rc) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_reset_pins();
        rst_n = 1'b1;
        wait_falls(T_ROWS + 1);
        chk(lp_falls == T_ROWS + 1, "R6 frame count after reset", lp_falls, T_ROWS + 1);
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

endmodule